// File: doc/BRIEF.md
# Dual-Bus Monitor Host Register Block

This block is the host-facing register and capture logic of a monitor that listens to two redundant serial buses. A word decoder outside the block delivers one strobe for each word received. The strobe carries the bus it came from, whether the word is a command or data, and whether it was valid or in error. The host reaches a 16-bit control register, a 32-entry receive FIFO and two last-word registers through a small read/write port. The register address used for each access is the OR of four control bits and four address pins.

One field of the control register picks which bus feeds message storage: bus A, bus B, or neither. Valid words still update the last-word register of their own bus, whichever bus is selected. Only valid data words on the selected bus enter the FIFO. Only errors on the selected bus raise the error output. A valid command on a bus that is not selected raises a one-cycle receive-alert pulse. The error output can clear in three ways: on the next valid command, on a rising edge of the error-reset control bit, or by itself after a fixed time while that bit stays high. The hold time is counted in clock cycles, and the count is scaled by the clock-rate bit. Writing control bit 0 high and then low performs a soft master reset, which clears everything except the control register.

Top module: `dbus_mon_regs`

## Requirements
- R1: A write (`wr_en`) updates the control register only when bit 2 of the effective address is 1. Otherwise it is ignored. Control bit 11 always reads back as 0.
- R2: The effective address is `ctrl[10:7] | addr_pin`. A read (`rd_en`) loads `rdata` on that clock edge as follows: 4'b1100 gives the control register, 4'b0100 pops the FIFO, 4'b1001 gives the bus A last word, 4'b1010 gives the bus B last word, and any other address gives 0.
- R3: Every valid word (`word_ok`=1, `word_err`=0) updates the last-word register of its bus (`word_bus` 0=A, 1=B). This happens whatever the bus selection is. Invalid words do not update it.
- R4: Bus selection is `ctrl[5:4]`: 2'b01 selects A, 2'b10 selects B, and 2'b11 or 2'b00 selects neither. Only valid data words (`word_cmd`=0) from the selected bus are written to the FIFO.
- R5: A valid command on a bus that is not selected drives `rcv` high for exactly the one cycle after the strobe. A valid command on the selected bus leaves `rcv` low.
- R6: The FIFO returns words in arrival order and holds up to 32 words. `fifo_empty` is 0 while any word is stored and goes to 1 after the last word is read.
- R7: A data word that arrives while the FIFO is full is dropped, and `fifo_ovf` is set. `fifo_ovf` stays set until a reset.
- R8: A FIFO read while `fifo_empty`=1 leaves `rdata` at its previous value and does not consume a later word.
- R9: An error strobe on the selected bus sets `error`. An error strobe on the other bus does not. While `ctrl[6]`=0, `error` clears only on a valid command from the selected bus.
- R10: A control write that changes `ctrl[6]` from 0 to 1 clears `error` on that edge.
- R11: While `ctrl[6]`=1, `error` clears by itself 80 cycles after it was set when `ctrl[12]`=0, and 40 cycles after it was set when `ctrl[12]`=1.
- R12: A control write that clears bit 0 while bit 0 is 1 empties the FIFO and clears `error`, `fifo_ovf`, both last-word registers and `rdata`. The new control value is still stored.
- R13: `op_mode` equals `ctrl[3:2] | mode_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset, clears all state including the control register |
| addr_pin | input | 4 | Register address pins, ORed with control bits 10:7 |
| mode_pin | input | 2 | Mode pins, ORed with control bits 3:2 |
| wr_en | input | 1 | Host write strobe |
| wdata | input | 16 | Host write data |
| rd_en | input | 1 | Host read strobe |
| rdata | output | 16 | Registered read data |
| word_stb | input | 1 | Decoded-word strobe, one cycle per word |
| word_bus | input | 1 | Bus of the word: 0=A, 1=B |
| word_cmd | input | 1 | 1 for a command word, 0 for a data word |
| word_ok | input | 1 | Word passed validation |
| word_err | input | 1 | Word had a receive error |
| word_data | input | 16 | Decoded word value |
| rcv | output | 1 | Pulse for a valid command on the bus that is not selected |
| error | output | 1 | Error flag |
| fifo_empty | output | 1 | Receive FIFO is empty |
| fifo_ovf | output | 1 | Sticky FIFO overflow flag |
| op_mode | output | 2 | Combined mode select |

## Verification
A table of host accesses checks address decoding in three cases: with the control address bits clear, with a control bit forcing address bit 2, and with pins and bits combined into addresses that do and do not map. This separates the OR function from plain pin decoding. Word traffic is driven in several forms: data and commands, valid and invalid, on the selected bus, on the other bus and with no bus selected. This shows that capture into the last-word registers is independent of the FIFO, `rcv` and `error` paths. The FIFO is filled past 32 words and then drained to confirm order, dropping and empty reads. `error` is cleared by each of its three paths, with the cycle count checked at both clock-rate settings just before and at the expected clear edge.

// File: rtl/dbus_mon_regs.sv
module dbus_mon_regs #(
  parameter int DW       = 16,
  parameter int DEPTH    = 32,
  parameter int TMO_FAST = 80,
  parameter int TMO_SLOW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    addr_pin,
  input  logic [1:0]    mode_pin,
  input  logic          wr_en,
  input  logic [15:0]   wdata,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  input  logic          word_stb,
  input  logic          word_bus,
  input  logic          word_cmd,
  input  logic          word_ok,
  input  logic          word_err,
  input  logic [DW-1:0] word_data,
  output logic          rcv,
  output logic          error,
  output logic          fifo_empty,
  output logic          fifo_ovf,
  output logic [1:0]    op_mode
);
  localparam int AW   = $clog2(DEPTH);
  localparam int TMAX = (TMO_FAST > TMO_SLOW) ? TMO_FAST : TMO_SLOW;
  localparam int TW   = $clog2(TMAX + 1);

  logic [15:0]   ctrl;
  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wp, rp;
  logic [DW-1:0] last_a, last_b;
  logic [TW-1:0] tmo;

  wire [3:0] ra       = ctrl[10:7] | addr_pin;
  wire       wr_ctl   = wr_en & ra[2];
  wire       soft_clr = wr_ctl & ctrl[0] & ~wdata[0];
  wire       clr_edge = wr_ctl & ~ctrl[6] & wdata[6];
  wire       sel_a    = ctrl[4] & ~ctrl[5];
  wire       sel_b    = ctrl[5] & ~ctrl[4];
  wire       on_act   = word_bus ? sel_b : sel_a;
  wire       good     = word_stb & word_ok & ~word_err;
  wire       push     = good & ~word_cmd & on_act;
  wire       err_set  = word_stb & word_err & on_act;
  wire       cmd_clr  = good & word_cmd & on_act;
  wire       full     = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  wire       pop      = rd_en & (ra == 4'b0100) & ~fifo_empty;
  wire [TW-1:0] tmo_lim = ctrl[12] ? TW'(TMO_SLOW - 1) : TW'(TMO_FAST - 1);
  wire       tmo_hit  = error & ctrl[6] & (tmo >= tmo_lim);

  assign fifo_empty = (wp == rp);
  assign op_mode    = ctrl[3:2] | mode_pin;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctrl <= '0;
    else if (wr_ctl) ctrl <= wdata & 16'hF7FF;

  always_ff @(posedge clk)
    if (push && !full) mem[wp[AW-1:0]] <= word_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fifo_ovf <= 1'b0; last_a <= '0; last_b <= '0;
      rcv <= 1'b0; error <= 1'b0; tmo <= '0; rdata <= '0;
    end else if (soft_clr) begin
      wp <= '0; rp <= '0; fifo_ovf <= 1'b0; last_a <= '0; last_b <= '0;
      rcv <= 1'b0; error <= 1'b0; tmo <= '0; rdata <= '0;
    end else begin
      if (push) begin
        if (!full) wp <= wp + 1'b1;
        else       fifo_ovf <= 1'b1;
      end
      if (pop) rp <= rp + 1'b1;
      if (good && !word_bus) last_a <= word_data;
      if (good &&  word_bus) last_b <= word_data;
      rcv <= good & word_cmd & ~on_act;
      if (err_set) begin
        error <= 1'b1;
        tmo   <= '0;
      end else if (cmd_clr || clr_edge || tmo_hit) begin
        error <= 1'b0;
        tmo   <= '0;
      end else if (error && ctrl[6]) begin
        tmo <= tmo + 1'b1;
      end
      if (rd_en) begin
        case (ra)
          4'b1100: rdata <= DW'(ctrl);
          4'b0100: if (!fifo_empty) rdata <= mem[rp[AW-1:0]];
          4'b1001: rdata <= last_a;
          4'b1010: rdata <= last_b;
          default: rdata <= '0;
        endcase
      end
    end
  end

  a_r9_other_bus_err: assert property (@(posedge clk) disable iff (!rst_n)
    (!error && !(word_stb && on_act)) |=> !error);
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_ovf && !soft_clr) |=> fifo_ovf);
  a_r6_empty_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && !push) |=> fifo_empty);
  a_r12_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (fifo_empty && !error && !fifo_ovf && rdata == '0));
  a_r10_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_edge && !err_set) |=> !error);
  a_r11_tmo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (tmo <= TW'(TMAX - 1)));
  a_r5_rcv_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rcv && !(good && word_cmd && !on_act)) |=> !rcv);
endmodule

// File: tb/tb_dbus_mon_regs.sv
module tb_dbus_mon_regs;
  localparam int TCLK = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] addr_pin = '0;
  logic [1:0] mode_pin = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wdata = '0, rdata, word_data = '0;
  logic word_stb = 1'b0, word_bus = 1'b0, word_cmd = 1'b0, word_ok = 1'b0, word_err = 1'b0;
  logic rcv, error, fifo_empty, fifo_ovf;
  logic [1:0] op_mode;
  int nvec = 0, nbad = 0;
  bit done = 1'b0;
  logic [15:0] got;

  dbus_mon_regs dut (
    .clk(clk), .rst_n(rst_n), .addr_pin(addr_pin), .mode_pin(mode_pin),
    .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en), .rdata(rdata),
    .word_stb(word_stb), .word_bus(word_bus), .word_cmd(word_cmd),
    .word_ok(word_ok), .word_err(word_err), .word_data(word_data),
    .rcv(rcv), .error(error), .fifo_empty(fifo_empty), .fifo_ovf(fifo_ovf),
    .op_mode(op_mode)
  );

  always #(TCLK/2) clk = ~clk;

  // {is_read, addr_pin, wdata, expected rdata}
  localparam logic [36:0] VEC [9] = '{
    {1'b0, 4'b0100, 16'h0810, 16'h0000},
    {1'b1, 4'b1100, 16'h0000, 16'h0010},
    {1'b0, 4'b0000, 16'hFFFF, 16'h0000},
    {1'b1, 4'b1100, 16'h0000, 16'h0010},
    {1'b0, 4'b0100, 16'h0210, 16'h0000},
    {1'b1, 4'b1000, 16'h0000, 16'h0210},
    {1'b0, 4'b0000, 16'h0010, 16'h0000},
    {1'b1, 4'b1000, 16'h0000, 16'h0000},
    {1'b1, 4'b1100, 16'h0000, 16'h0010}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] pins, input logic [15:0] d);
    @(negedge clk); addr_pin = pins; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; addr_pin = '0;
  endtask

  task automatic rd(input logic [3:0] pins, output logic [15:0] q);
    @(negedge clk); addr_pin = pins; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; addr_pin = '0; q = rdata;
  endtask

  task automatic wd(input logic b, input logic c, input logic ok, input logic e, input logic [15:0] d);
    @(negedge clk); word_stb = 1'b1; word_bus = b; word_cmd = c; word_ok = ok; word_err = e; word_data = d;
    @(negedge clk); word_stb = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset empty", 16'(fifo_empty), 16'd1);
    chk("R9 reset error", 16'(error), 16'd0);
    chk("R7 reset ovf", 16'(fifo_ovf), 16'd0);
    chk("R5 reset rcv", 16'(rcv), 16'd0);
    chk("R2 reset rdata", rdata, 16'h0000);

    // R1 R2 address decode table
    foreach (VEC[i]) begin
      if (VEC[i][36]) begin
        rd(VEC[i][35:32], got);
        chk($sformatf("R1/R2 vector %0d", i), got, VEC[i][15:0]);
      end else begin
        wr(VEC[i][35:32], VEC[i][31:16]);
      end
    end

    // R13 mode OR
    wr(4'b0100, 16'h0018); mode_pin = 2'b01;
    @(negedge clk); chk("R13 mode or", 16'(op_mode), 16'd3);
    wr(4'b0100, 16'h0010); mode_pin = 2'b00;
    @(negedge clk); chk("R13 mode clear", 16'(op_mode), 16'd0);

    // R3 last-word capture, bus A selected
    wd(0, 0, 1, 0, 16'h1111);
    wd(1, 0, 1, 0, 16'h2222);
    wd(1, 0, 0, 0, 16'h3333);
    rd(4'b1001, got); chk("R3 bus A word", got, 16'h1111);
    rd(4'b1010, got); chk("R3 bus B word", got, 16'h2222);

    // R5 rcv
    wd(1, 1, 1, 0, 16'h4444); chk("R5 rcv other bus", 16'(rcv), 16'd1);
    @(negedge clk); chk("R5 rcv one cycle", 16'(rcv), 16'd0);
    wd(0, 1, 1, 0, 16'h4545); chk("R5 rcv selected bus", 16'(rcv), 16'd0);

    // R4 only the bus A data word entered the FIFO; R8 empty read
    rd(4'b0100, got); chk("R4 fifo content", got, 16'h1111);
    chk("R6 empty after last", 16'(fifo_empty), 16'd1);
    rd(4'b0100, got); chk("R8 empty read holds", got, 16'h1111);

    // R6 R7 fill past depth
    for (int i = 0; i < 32; i++) wd(0, 0, 1, 0, 16'hA000 + 16'(i));
    chk("R6 not empty", 16'(fifo_empty), 16'd0);
    chk("R7 no ovf at 32", 16'(fifo_ovf), 16'd0);
    wd(0, 0, 1, 0, 16'hBEEF);
    chk("R7 ovf set", 16'(fifo_ovf), 16'd1);
    for (int i = 0; i < 32; i++) begin
      rd(4'b0100, got);
      chk($sformatf("R6 order %0d", i), got, 16'hA000 + 16'(i));
    end
    chk("R6 empty after drain", 16'(fifo_empty), 16'd1);
    rd(4'b0100, got); chk("R7 dropped word absent", got, 16'hA01F);
    chk("R7 ovf sticky", 16'(fifo_ovf), 16'd1);

    // R4 no bus selected
    wr(4'b0100, 16'h0030);
    wd(0, 0, 1, 0, 16'h7777);
    chk("R4 neither selected", 16'(fifo_empty), 16'd1);
    rd(4'b1001, got); chk("R3 capture unselected", got, 16'h7777);
    wr(4'b0100, 16'h0010);

    // R9 error paths
    wd(1, 0, 0, 1, 16'h0);  chk("R9 other bus err", 16'(error), 16'd0);
    wd(0, 0, 0, 1, 16'h0);  chk("R9 err set", 16'(error), 16'd1);
    repeat (100) @(negedge clk);
    chk("R9 no timeout bit6 low", 16'(error), 16'd1);
    wd(0, 0, 1, 0, 16'h0);  chk("R9 data no clear", 16'(error), 16'd1);
    wd(0, 1, 1, 0, 16'h0);  chk("R9 cmd clears", 16'(error), 16'd0);

    // R10 edge clear
    wd(0, 0, 0, 1, 16'h0);
    wr(4'b0100, 16'h0050);  chk("R10 edge clears", 16'(error), 16'd0);

    // R11 timeouts
    wd(0, 0, 0, 1, 16'h0);
    repeat (79) @(negedge clk); chk("R11 fast held", 16'(error), 16'd1);
    @(negedge clk);             chk("R11 fast clear", 16'(error), 16'd0);
    wr(4'b0100, 16'h1050);
    wd(0, 0, 0, 1, 16'h0);
    repeat (39) @(negedge clk); chk("R11 slow held", 16'(error), 16'd1);
    @(negedge clk);             chk("R11 slow clear", 16'(error), 16'd0);

    // R12 soft master reset
    wr(4'b0100, 16'h0011);
    wd(0, 0, 0, 1, 16'h0);
    wd(0, 0, 1, 0, 16'h5555);
    rd(4'b1001, got);
    chk("R12 pre err", 16'(error), 16'd1);
    wr(4'b0100, 16'h0010);
    chk("R12 rdata cleared", rdata, 16'h0000);
    chk("R12 fifo empty", 16'(fifo_empty), 16'd1);
    chk("R12 error cleared", 16'(error), 16'd0);
    chk("R12 ovf cleared", 16'(fifo_ovf), 16'd0);
    rd(4'b1001, got); chk("R12 last word cleared", got, 16'h0000);
    rd(4'b1100, got); chk("R12 ctrl kept", got, 16'h0010);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule